// File: doc/BRIEF.md
# Programmable Two-Digit Combination Lock

This block is the controller of an electronic door lock. A user sets a 2-bit code on switches and confirms it with an Enter pulse, twice. The block compares the two entries with a stored two-digit combination and reports either Open or Error. Error is held back until the second entry, so an observer cannot tell which digit was wrong.

While the lock is open, further Enter presses walk through a reprogramming sequence. The first press requests the new first digit. The second press stores it and requests the new second digit. The third press stores that digit and returns to the open state.

The system reset relocks the door but keeps the stored combination. A separate combination-reset input restores the factory pair: first digit 2'b11, second digit 2'b01. All outputs are Moore outputs, taken from registers that follow the controller state. A debug LED bus shows the state code and the four status flags.

Top module: `combo_lock`

## Requirements
- R1: Asserting `combo_rst_i` for one clock loads the default combination (first digit 2'b11, second digit 2'b01). Entering 3 and then 1 afterwards opens the lock.
- R2: `rst` high at a clock edge returns the controller to idle. All four flags go low and `led_o[2:0]` reads 0. The stored combination is left unchanged.
- R3: A first entry equal to the stored first digit, followed by a second entry equal to the stored second digit, raises `open_o`. No other entry sequence does this.
- R4: A first entry that does not match raises no flag. The following entry, whatever its code, raises `error_o`.
- R5: A matching first entry followed by a non-matching second entry raises `error_o`.
- R6: In the error state, the next entry is treated as a fresh first-digit attempt. It goes to the "first digit good" state or the "first digit bad" state.
- R7: The reprogramming sequence works as follows:
  - In the open state, a press raises `prog1_o`.
  - The next press stores `code_i` as the first digit and raises `prog2_o`.
  - The press after that stores `code_i` as the second digit and raises `open_o` again.
  - Later unlocks need the new pair.
- R8: A press is a rising edge of `enter_i`. Holding `enter_i` high for several cycles advances the controller once. Cycles with `enter_i` low change nothing.
- R9: At most one of `open_o`, `error_o`, `prog1_o` and `prog2_o` is high at any time. All four are low in idle and in both waiting states.
- R10: `led_o` is encoded as follows:
  - `led_o[2:0]` holds the state code: idle 0, first digit good 1, first digit bad 2, open 3, error 4, program first 5, program second 6.
  - `led_o[3]` is 0.
  - `led_o[7:4]` holds {prog2, prog1, error, open}.
  - Any higher bits are 0.
- R11: `combo_rst_i` does not change the controller state. If it coincides with a press that would store a digit, the defaults win for the digit store, while the state still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset, leaves the combination alone |
| code_i | input | DIGIT_W | Code switches |
| enter_i | input | 1 | Enter button level |
| combo_rst_i | input | 1 | Restore default combination |
| open_o | output | 1 | Lock open |
| error_o | output | 1 | Wrong combination entered |
| prog1_o | output | 1 | Awaiting new first digit |
| prog2_o | output | 1 | Awaiting new second digit |
| led_o | output | LED_W | Debug view of state and flags |

## Verification
Every flag and the LED bus are due at the first clock edge that samples the rising edge of `enter_i`. The same holds for the first edge with `rst` high, and a digit store lands at that edge too. The bench changes inputs on falling edges and reads outputs at the next falling edge, half a cycle after the edge that updates them. For held presses it checks again on each later falling edge that nothing has moved. The effect of a combination reset is observed through later unlock attempts, compared with a bench model of the state and the two stored digits.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_OK  = 3'd1,
    ST_WAIT_BAD = 3'd2,
    ST_OPEN     = 3'd3,
    ST_ERROR    = 3'd4,
    ST_PROG1    = 3'd5,
    ST_PROG2    = 3'd6
  } lock_state_e;

  typedef struct packed {
    logic prog2;
    logic prog1;
    logic error;
    logic open;
  } lock_flags_t;

  localparam int STATE_W = 3;
  localparam int FLAGS_W = 4;

  function automatic lock_flags_t flags_of(lock_state_e s);
    lock_flags_t f;
    f       = '0;
    f.open  = (s == ST_OPEN);
    f.error = (s == ST_ERROR);
    f.prog1 = (s == ST_PROG1);
    f.prog2 = (s == ST_PROG2);
    return f;
  endfunction

endpackage

// File: rtl/press_edge.sv
module press_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic press_o
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_i;
  end

  assign press_o = level_i & ~level_q;
endmodule

// File: rtl/digit_store.sv
module digit_store #(
  parameter int DIGIT_W    = 2,
  parameter int NUM_DIGITS = 2,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] DEFAULTS = '0
) (
  input  logic                          clk,
  input  logic                          load_defaults_i,
  input  logic [NUM_DIGITS-1:0]         wr_en_i,
  input  logic [DIGIT_W-1:0]            wr_data_i,
  output logic [NUM_DIGITS*DIGIT_W-1:0] digits_o
);
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_slot
    logic [DIGIT_W-1:0] slot_q;

    always_ff @(posedge clk) begin
      if (load_defaults_i)  slot_q <= DEFAULTS[g*DIGIT_W +: DIGIT_W];
      else if (wr_en_i[g])  slot_q <= wr_data_i;
    end

    assign digits_o[g*DIGIT_W +: DIGIT_W] = slot_q;
  end
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import combo_lock_pkg::*;
#(
  parameter int DIGIT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               press_i,
  input  logic [DIGIT_W-1:0] code_i,
  input  logic [DIGIT_W-1:0] first_i,
  input  logic [DIGIT_W-1:0] second_i,
  output lock_state_e        state_o,
  output lock_flags_t        flags_o,
  output logic               wr_first_o,
  output logic               wr_second_o
);
  lock_state_e state_q, state_d;
  lock_flags_t flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      flags_q <= '0;
    end else begin
      state_q <= state_d;
      flags_q <= flags_of(state_d);
    end
  end

  always_comb begin
    state_d     = state_q;
    wr_first_o  = 1'b0;
    wr_second_o = 1'b0;
    if (press_i) begin
      case (state_q)
        ST_IDLE, ST_ERROR:
          state_d = (code_i == first_i) ? ST_WAIT_OK : ST_WAIT_BAD;
        ST_WAIT_OK:
          state_d = (code_i == second_i) ? ST_OPEN : ST_ERROR;
        ST_WAIT_BAD:
          state_d = ST_ERROR;
        ST_OPEN:
          state_d = ST_PROG1;
        ST_PROG1: begin
          wr_first_o = 1'b1;
          state_d    = ST_PROG2;
        end
        ST_PROG2: begin
          wr_second_o = 1'b1;
          state_d     = ST_OPEN;
        end
        default:
          state_d = ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import combo_lock_pkg::*;
#(
  parameter int               DIGIT_W    = 2,
  parameter int               LED_W      = 8,
  parameter logic [DIGIT_W-1:0] DEF_FIRST  = 2'b11,
  parameter logic [DIGIT_W-1:0] DEF_SECOND = 2'b01
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] code_i,
  input  logic               enter_i,
  input  logic               combo_rst_i,
  output logic               open_o,
  output logic               error_o,
  output logic               prog1_o,
  output logic               prog2_o,
  output logic [LED_W-1:0]   led_o
);
  localparam int NUM_DIGITS = 2;
  localparam int VIEW_W     = FLAGS_W + 1 + STATE_W;
  localparam logic [NUM_DIGITS*DIGIT_W-1:0] DEFAULTS = {DEF_SECOND, DEF_FIRST};

  logic                          press;
  logic [NUM_DIGITS*DIGIT_W-1:0] digits;
  logic [DIGIT_W-1:0]            digit1, digit2;
  logic                          wr_first, wr_second;
  lock_state_e                   state_q;
  lock_flags_t                   flags_q;
  logic [VIEW_W-1:0]             led_view;

  press_edge u_press (
    .clk     (clk),
    .rst     (rst),
    .level_i (enter_i),
    .press_o (press)
  );

  digit_store #(
    .DIGIT_W    (DIGIT_W),
    .NUM_DIGITS (NUM_DIGITS),
    .DEFAULTS   (DEFAULTS)
  ) u_store (
    .clk             (clk),
    .load_defaults_i (combo_rst_i),
    .wr_en_i         ({wr_second, wr_first}),
    .wr_data_i       (code_i),
    .digits_o        (digits)
  );

  assign digit1 = digits[0 +: DIGIT_W];
  assign digit2 = digits[DIGIT_W +: DIGIT_W];

  lock_ctrl #(.DIGIT_W(DIGIT_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .press_i     (press),
    .code_i      (code_i),
    .first_i     (digit1),
    .second_i    (digit2),
    .state_o     (state_q),
    .flags_o     (flags_q),
    .wr_first_o  (wr_first),
    .wr_second_o (wr_second)
  );

  assign open_o   = flags_q.open;
  assign error_o  = flags_q.error;
  assign prog1_o  = flags_q.prog1;
  assign prog2_o  = flags_q.prog2;
  assign led_view = {flags_q, 1'b0, state_q};
  assign led_o    = LED_W'(led_view);
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk #(
  parameter int                 DIGIT_W    = 2,
  parameter int                 LED_W      = 8,
  parameter logic [DIGIT_W-1:0] DEF_FIRST  = 2'b11,
  parameter logic [DIGIT_W-1:0] DEF_SECOND = 2'b01
) (
  input logic               clk,
  input logic               rst,
  input logic [DIGIT_W-1:0] code_i,
  input logic               enter_i,
  input logic               combo_rst_i,
  input logic               press,
  input logic [DIGIT_W-1:0] digit1,
  input logic [DIGIT_W-1:0] digit2,
  input logic               open_o,
  input logic               error_o,
  input logic               prog1_o,
  input logic               prog2_o,
  input logic [LED_W-1:0]   led_o
);
  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({open_o, error_o, prog1_o, prog2_o}));

  p_reset_idle_r2: assert property (@(posedge clk)
    rst |=> (led_o[2:0] == 3'd0 && !open_o && !error_o && !prog1_o && !prog2_o));

  p_hold_when_low_r8: assert property (@(posedge clk) disable iff (rst)
    !enter_i |=> $stable(led_o));

  p_error_late_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(error_o) |-> ($past(led_o[2:0]) == 3'd1 || $past(led_o[2:0]) == 3'd2));

  p_open_needs_match_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(open_o) |-> (($past(led_o[2:0]) == 3'd1 && $past(code_i) == $past(digit2))
                       || $past(led_o[2:0]) == 3'd6));

  p_store_first_r7: assert property (@(posedge clk) disable iff (rst)
    (led_o[2:0] == 3'd5 && press && !combo_rst_i) |=> (digit1 == $past(code_i)));

  p_combo_default_r1: assert property (@(posedge clk) disable iff (rst)
    combo_rst_i |=> (digit1 == DEF_FIRST && digit2 == DEF_SECOND));
endmodule

bind combo_lock combo_lock_chk #(
  .DIGIT_W    (DIGIT_W),
  .LED_W      (LED_W),
  .DEF_FIRST  (DEF_FIRST),
  .DEF_SECOND (DEF_SECOND)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .code_i      (code_i),
  .enter_i     (enter_i),
  .combo_rst_i (combo_rst_i),
  .press       (press),
  .digit1      (digit1),
  .digit2      (digit2),
  .open_o      (open_o),
  .error_o     (error_o),
  .prog1_o     (prog1_o),
  .prog2_o     (prog2_o),
  .led_o       (led_o)
);

// File: tb/combo_lock_tb.sv
`timescale 1ns/1ps
module combo_lock_tb;
  localparam int DIGIT_W = 2;
  localparam int LED_W   = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [DIGIT_W-1:0] code_i = '0;
  logic               enter_i = 1'b0;
  logic               combo_rst_i = 1'b0;
  logic               open_o, error_o, prog1_o, prog2_o;
  logic [LED_W-1:0]   led_o;

  int n_vec  = 0;
  int n_fail = 0;

  int       m_state = 0;
  logic [1:0] m_d1 = 2'b11;
  logic [1:0] m_d2 = 2'b01;

  always #2 clk = ~clk;

  combo_lock u_dut (
    .clk(clk), .rst(rst), .code_i(code_i), .enter_i(enter_i),
    .combo_rst_i(combo_rst_i), .open_o(open_o), .error_o(error_o),
    .prog1_o(prog1_o), .prog2_o(prog2_o), .led_o(led_o)
  );

  function automatic logic [7:0] exp_led(int s);
    logic [3:0] f;
    f = {s == 6, s == 5, s == 4, s == 3};
    return {f, 1'b0, 3'(s)};
  endfunction

  function automatic int next_state(int s, logic [1:0] c, logic [1:0] d1, logic [1:0] d2);
    case (s)
      0, 4:    return (c == d1) ? 1 : 2;
      1:       return (c == d2) ? 3 : 4;
      2:       return 4;
      3:       return 5;
      5:       return 6;
      6:       return 3;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag);
    logic [7:0] e;
    e = exp_led(m_state);
    n_vec++;
    if (led_o !== e || open_o !== e[4] || error_o !== e[5] ||
        prog1_o !== e[6] || prog2_o !== e[7]) begin
      n_fail++;
      $display("FAIL %s: led=%b flags(o,e,p1,p2)=%b%b%b%b expected led=%b",
               tag, led_o, open_o, error_o, prog1_o, prog2_o, e);
    end
  endtask

  // One press: combo may coincide with it; hold = cycles enter stays high.
  task automatic press(logic [1:0] c, bit combo, int hold, string tag);
    int ns;
    @(negedge clk);
    code_i = c; enter_i = 1'b1; combo_rst_i = combo;
    ns = next_state(m_state, c, m_d1, m_d2);
    if (m_state == 5) m_d1 = c;
    if (m_state == 6) m_d2 = c;
    if (combo) begin m_d1 = 2'b11; m_d2 = 2'b01; end
    m_state = ns;
    @(negedge clk);
    combo_rst_i = 1'b0;
    check(tag);
    for (int k = 1; k < hold; k++) begin
      @(negedge clk);
      check({tag, " held"});
    end
    enter_i = 1'b0;
    @(negedge clk);
    check({tag, " released"});
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_state = 0;
    check(tag);
  endtask

  task automatic do_combo(string tag);
    @(negedge clk);
    combo_rst_i = 1'b1;
    m_d1 = 2'b11; m_d2 = 2'b01;
    @(negedge clk);
    combo_rst_i = 1'b0;
    check(tag);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h1CE5);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    do_reset("R2 reset state");
    do_combo("R11 combo reset leaves state, R1");
    press(2'b11, 0, 1, "R9 R10 first digit good");
    press(2'b01, 0, 1, "R1 R3 default pair opens");
    press(2'b10, 0, 1, "R7 open to prog1");
    press(2'b00, 0, 1, "R7 store first");
    press(2'b10, 0, 1, "R7 store second");
    do_reset("R2 reset from open");
    press(2'b11, 0, 1, "R4 bad first no flag");
    press(2'b01, 0, 1, "R4 error after second");
    press(2'b00, 0, 1, "R6 fresh attempt from error");
    press(2'b10, 0, 1, "R7 new pair opens");
    do_reset("R2 reset keeps combo");
    press(2'b00, 0, 1, "R2 kept first digit");
    press(2'b11, 0, 1, "R5 wrong second");
    press(2'b10, 0, 4, "R8 held enter single step");
    press(2'b00, 0, 1, "R8 R5 second after held");
    do_reset("R2 reset");
    press(2'b00, 0, 1, "R3");
    press(2'b10, 0, 1, "R3 open");
    press(2'b01, 0, 1, "R7 prog1");
    press(2'b10, 1, 1, "R11 combo beats store");
    press(2'b00, 0, 1, "R11 store second");
    do_reset("R2");
    press(2'b11, 0, 1, "R11 first default kept");
    press(2'b00, 0, 1, "R11 second newly stored");
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [1:0] c;
      r = int'($urandom_range(99));
      if (r < 3) do_reset("R2 random reset");
      else if (r < 7) do_combo("R1 R11 random combo reset");
      else begin
        c = 2'($urandom);
        if ($urandom_range(1) == 1) c = (m_state == 1) ? m_d2 : m_d1;
        press(c, $urandom_range(19) == 0, int'($urandom_range(3)) + 1,
              "R3 R4 R5 R6 R7 R8 R9 R10 random");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule